// File: doc/BRIEF.md
# Stalled-Rotor Guard

This block watches a three-phase brushless motor for a stalled rotor. A slow timing oscillator supplies one tick per period, and a counter adds one per tick while the motor is commanded to run. Every transition of the parity of the three Hall sensor lines resets the counter, so a turning rotor keeps it near zero. When enough ticks pass without a Hall edge, the counter carries out of its top bit and `stall_detect` rises.

A set stall raises `stall_protect` on the next clock. This flag holds the bridge driver suspended, and it stays set after the rotor turns again. Only three events clear it: power-on reset, a change of the run command, or a change of the direction command. Both of these command changes also reset the counter. While the run command is inactive, the counter stays at zero and `stall_detect` stays low.

The oscillator is modelled as a tick input. With a 16-bit counter the stall timeout is 65,536 ticks. The tick rate is chosen so that this matches a timeout of about two seconds. All inputs are plain level pins that pass through one register stage. There is no stream traffic, so there is no valid/ready handshake.

Top module: `stalled_rotor_guard`

## Requirements
- R1: While `rst_n` is low, and after it is released, both `stall_detect` and `stall_protect` read 0. Asserting `rst_n` clears a set protection latch.
- R2: While `run_en` is 1, the counter advances by one for each clock in which the registered `osc_tick` is 1. Fewer than 2^CNT_W ticks since the last clear leave `stall_detect` at 0.
- R3: A transition on any single Hall line clears the counter. If a clear and a tick fall in the same cycle, the clear wins and the tick is not counted.
- R4: The 2^CNT_W-th tick since the last clear sets `stall_detect`. A tick driven high before rising edge k sets `stall_detect` after edge k+1. The flag stays 1 while the counter wraps, until a clear event.
- R5: `stall_protect` becomes 1 on the clock after `stall_detect` is 1.
- R6: `stall_protect` stays 1 when Hall edges resume. A Hall edge clears `stall_detect`.
- R7: Any change of `run_en` or `dir_sel` clears the counter, `stall_detect` and `stall_protect`.
- R8: While `run_en` is 0, the counter is held at zero, ticks have no effect and `stall_detect` stays 0.
- R9: If two Hall lines change in the same cycle, the parity is unchanged. This is not a clear, and counting continues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| hall_a | input | 1 | Squared Hall sensor, phases A-B |
| hall_b | input | 1 | Squared Hall sensor, phases B-C |
| hall_c | input | 1 | Squared Hall sensor, phases C-A |
| osc_tick | input | 1 | One-clock pulse per timing-oscillator period |
| run_en | input | 1 | 1 commands the motor to run |
| dir_sel | input | 1 | Rotation direction command |
| stall_detect | output | 1 | Counter has overflowed since the last clear |
| stall_protect | output | 1 | Latched stall, holds the driver suspended |

## Verification
The bench builds the guard with CNT_W set to 3, so eight ticks give a stall. This brings into a few dozen clocks several cases that a 16-bit counter would push tens of thousands of ticks away. These cases are the exact overflow cycle, a counter wrap with the flag held, a stall reached again after each clear source, and a clear racing a tick. The default width of 16 is only elaborated. It differs from the bench build in timeout length alone.

// File: rtl/srg_pkg.sv
package srg_pkg;
  localparam int HALL_N = 3;

  typedef struct packed {
    logic [HALL_N-1:0] hall;
    logic              run;
    logic              dir;
  } srg_lvl_t;
endpackage

// File: rtl/srg_sampler.sv
module srg_sampler
  import srg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALL_N-1:0] hall_raw,
  input  logic              tick_raw,
  input  logic              run_raw,
  input  logic              dir_raw,
  output logic              tick_q,
  output logic              run_q,
  output logic              hall_evt,
  output logic              run_evt,
  output logic              dir_evt
);
  srg_lvl_t          cur;
  srg_lvl_t          prev;
  logic [HALL_N-1:0] line_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur    <= '0;
      prev   <= '0;
      tick_q <= 1'b0;
    end else begin
      cur    <= '{hall: hall_raw, run: run_raw, dir: dir_raw};
      prev   <= cur;
      tick_q <= tick_raw;
    end
  end

  for (genvar i = 0; i < HALL_N; i++) begin : g_line
    assign line_chg[i] = cur.hall[i] ^ prev.hall[i];
  end

  // parity of all lines changed: an odd number of lines moved
  assign hall_evt = ^line_chg;
  assign run_evt  = cur.run ^ prev.run;
  assign dir_evt  = cur.dir ^ prev.dir;
  assign run_q    = cur.run;

  assert_single_edge_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(line_chg) == 1) |-> hall_evt);
  assert_double_edge_no_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(line_chg) == 2) |-> !hall_evt);
endmodule

// File: rtl/srg_stall_counter.sv
module srg_stall_counter #(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic clr,
  output logic carry
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           count <= '0;
    else if (!run || clr) count <= '0;
    else if (tick)        count <= count + 1'b1;
  end

  assign carry = run && !clr && tick && (count == CNT_MAX);

  assert_idle_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count == '0));
  assert_clear_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && tick) |=> (count == $past(count) + 1'b1));
  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !tick) |=> $stable(count));
endmodule

// File: rtl/srg_protect_latch.sv
module srg_protect_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic carry,
  input  logic hall_evt,
  input  logic ctl_evt,
  output logic detect,
  output logic protect
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           detect <= 1'b0;
    else if (!run || ctl_evt || hall_evt) detect <= 1'b0;
    else if (carry)                       detect <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       protect <= 1'b0;
    else if (ctl_evt) protect <= 1'b0;
    else if (detect)  protect <= 1'b1;
  end

  assert_latch_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (detect && !ctl_evt) |=> protect);
  assert_latch_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (protect && !ctl_evt) |=> protect);
  assert_latch_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_evt |=> (!protect && !detect));
endmodule

// File: rtl/stalled_rotor_guard.sv
module stalled_rotor_guard #(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hall_a,
  input  logic hall_b,
  input  logic hall_c,
  input  logic osc_tick,
  input  logic run_en,
  input  logic dir_sel,
  output logic stall_detect,
  output logic stall_protect
);
  import srg_pkg::*;

  logic tick_q, run_q, hall_evt, run_evt, dir_evt;
  logic ctl_evt, clr, carry;

  srg_sampler u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .hall_raw ({hall_c, hall_b, hall_a}),
    .tick_raw (osc_tick),
    .run_raw  (run_en),
    .dir_raw  (dir_sel),
    .tick_q   (tick_q),
    .run_q    (run_q),
    .hall_evt (hall_evt),
    .run_evt  (run_evt),
    .dir_evt  (dir_evt)
  );

  assign ctl_evt = run_evt | dir_evt;
  assign clr     = ctl_evt | hall_evt;

  srg_stall_counter #(.CNT_W(CNT_W)) u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_q),
    .tick  (tick_q),
    .clr   (clr),
    .carry (carry)
  );

  srg_protect_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .carry    (carry),
    .hall_evt (hall_evt),
    .ctl_evt  (ctl_evt),
    .detect   (stall_detect),
    .protect  (stall_protect)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!stall_detect && !stall_protect));
  assert_rise_from_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_detect) |-> $past(carry));
  assert_idle_no_detect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !stall_detect);
endmodule

// File: tb/stalled_rotor_guard_tb.sv
`timescale 1ns/1ps
module stalled_rotor_guard_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hall_a = 1'b0, hall_b = 1'b0, hall_c = 1'b0;
  logic osc_tick = 1'b0, run_en = 1'b0, dir_sel = 1'b0;
  logic stall_detect, stall_protect;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  stalled_rotor_guard #(.CNT_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .hall_a(hall_a), .hall_b(hall_b), .hall_c(hall_c),
    .osc_tick(osc_tick), .run_en(run_en), .dir_sel(dir_sel),
    .stall_detect(stall_detect), .stall_protect(stall_protect)
  );

  localparam logic [2:0] OP_RUN = 3'd0, OP_TICK = 3'd1, OP_HALLA = 3'd2,
                         OP_HALL2 = 3'd3, OP_HALLB = 3'd4, OP_DIR = 3'd5;

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] arg;
    logic       det;
    logic       prot;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{OP_RUN,   8'd1,  1'b0, 1'b0, 4'd8}, // R8 run starts, quiet
    '{OP_TICK,  8'd7,  1'b0, 1'b0, 4'd2}, // R2 seven ticks: below overflow
    '{OP_HALLA, 8'd0,  1'b0, 1'b0, 4'd3}, // R3 single edge clears
    '{OP_TICK,  8'd7,  1'b0, 1'b0, 4'd3}, // R3 total 14 would stall without clear
    '{OP_TICK,  8'd1,  1'b1, 1'b1, 4'd4}, // R4 eighth tick overflows
    '{OP_HALLB, 8'd0,  1'b0, 1'b1, 4'd6}, // R6 rotor turns, latch holds
    '{OP_TICK,  8'd3,  1'b0, 1'b1, 4'd6}, // R6 still latched
    '{OP_DIR,   8'd0,  1'b0, 1'b0, 4'd7}, // R7 direction change clears
    '{OP_TICK,  8'd8,  1'b1, 1'b1, 4'd4}, // R4 stall again
    '{OP_RUN,   8'd0,  1'b0, 1'b0, 4'd7}, // R7 run change clears
    '{OP_TICK,  8'd20, 1'b0, 1'b0, 4'd8}, // R8 ticks ignored while stopped
    '{OP_RUN,   8'd1,  1'b0, 1'b0, 4'd8}, // R8 counter was held at zero
    '{OP_TICK,  8'd6,  1'b0, 1'b0, 4'd2}, // R2
    '{OP_HALL2, 8'd0,  1'b0, 1'b0, 4'd9}, // R9 two lines at once: no clear
    '{OP_TICK,  8'd2,  1'b1, 1'b1, 4'd9}, // R9 6+2 reaches overflow
    '{OP_TICK,  8'd5,  1'b1, 1'b1, 4'd4}, // R4 wraps, flag held
    '{OP_RUN,   8'd0,  1'b0, 1'b0, 4'd7}  // R7
  };

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) osc_tick = 1'b1;
      @(negedge clk) osc_tick = 1'b0;
    end
  endtask

  task automatic chk(input logic ed, input logic ep, input int req, input string what);
    total++;
    if (stall_detect !== ed || stall_protect !== ep) begin
      fails++;
      $display("FAIL R%0d %s: detect=%b protect=%b expected detect=%b protect=%b",
               req, what, stall_detect, stall_protect, ed, ep);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL R1 watchdog: state=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R1 reset state
    wait_cyc(3);
    chk(1'b0, 1'b0, 1, "during reset");
    rst_n = 1'b1;
    wait_cyc(3);

    foreach (VECS[v]) begin
      case (VECS[v].op)
        OP_RUN:   begin @(negedge clk) run_en = VECS[v].arg[0]; end
        OP_TICK:  do_ticks(int'(VECS[v].arg));
        OP_HALLA: begin @(negedge clk) hall_a = ~hall_a; end
        OP_HALLB: begin @(negedge clk) hall_b = ~hall_b; end
        OP_HALL2: begin @(negedge clk) begin hall_a = ~hall_a; hall_c = ~hall_c; end end
        OP_DIR:   begin @(negedge clk) dir_sel = ~dir_sel; end
        default:  ;
      endcase
      wait_cyc(3);
      chk(VECS[v].det, VECS[v].prot, int'(VECS[v].req), $sformatf("vector %0d", v));
    end

    // R3 clear and tick in same cycle: clear wins
    @(negedge clk) run_en = 1'b1;
    wait_cyc(3);
    do_ticks(7);
    @(negedge clk) begin osc_tick = 1'b1; hall_c = ~hall_c; end
    @(negedge clk) osc_tick = 1'b0;
    wait_cyc(2);
    do_ticks(7);
    wait_cyc(3);
    chk(1'b0, 1'b0, 3, "tick coinciding with clear not counted");
    do_ticks(1);
    wait_cyc(3);
    chk(1'b1, 1'b1, 4, "eighth tick after clear");

    // R1 power cycle clears latch
    @(negedge clk) rst_n = 1'b0;
    wait_cyc(2);
    chk(1'b0, 1'b0, 1, "reset clears latch");
    rst_n = 1'b1;
    wait_cyc(3);
    chk(1'b0, 1'b0, 1, "after reset release");

    // R4 / R5 exact cycle of overflow and latch
    do_ticks(7);
    wait_cyc(2);
    @(negedge clk) osc_tick = 1'b1;
    @(negedge clk) osc_tick = 1'b0;
    chk(1'b0, 1'b0, 4, "one edge after tick");
    @(negedge clk);
    chk(1'b1, 1'b0, 4, "two edges after tick");
    @(negedge clk);
    chk(1'b1, 1'b1, 5, "latch one clock after detect");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule